// File: doc/BRIEF.md
# Addressed Serial Code Loader for an Eight-Channel DAC

This block is the digital front end of an eight-channel DAC. A host sends 16-bit words over three wires: a data line, a shift clock and a load strobe. Each word names a device, a channel and an 8-bit code. When the load strobe rises, the block compares the device field with four strap inputs tied on the board. It then decodes the channel field and writes the code into one of eight output code registers. The analog side reads those registers as eight parallel 8-bit buses.

Several devices can share the data, clock and load lines in a chain. The bit that leaves the top of each shift register is latched and presented on a serial output, which feeds the next device. Because every word carries its own device address, only the device whose straps match acts on a shared load.

All three serial pins and the straps are asynchronous to the block. They pass through two-flop synchronisers onto a single system clock, and the shift clock and load are acted on only at their rising edges. The active-low reset is asynchronous and returns every channel to midscale.

Top module: `dacld_top`

## Requirements
- R1: While reset is low, and afterwards until the first write, every channel code reads 8'h80 and the serial output enable is 0.
- R2: Each rising edge of the shift clock, seen while load is low, shifts the data pin into the 16-bit word MSB first. Word bits [15:12] are the device address, bits [11:8] are the channel and bits [7:0] are the code. On a rising edge of load, the code is written to the named channel.
- R3: When the device address differs from the straps (strap bit 0 is the LSB), a load leaves every channel unchanged.
- R4: A channel field from 8 to 15 selects no register, and a load with such a field leaves every channel unchanged.
- R5: A load changes at most the one addressed channel, and the other seven keep their codes.
- R6: Shift clock edges that arrive while load is high do not shift the word and do not change the serial output.
- R7: The serial output holds the bit most recently pushed out of word bit 15, updated on each shift. Its enable follows the load level: 1 while load is high and 0 while it is low.
- R8: A write happens only on a rising edge of load. If the straps change while load stays high, no write follows.
- R9: Asserting reset after writes returns all eight channels to 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, sets all channels to midscale |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Load strobe, active high |
| strap | input | CS_W | Board-strapped device address |
| ser_dout | output | 1 | Chained serial output bit |
| ser_dout_en | output | 1 | Drive enable for the serial output |
| codes | output | N_CH*CODE_W | Channel codes, channel i in bits [8i+7:8i] |

## Verification
The hardest cases to reach from the pins are those where the load level stays high but something else changes. One is a shift clock pulse that must not move the chained bit. The other is a strap change that must not be taken as a fresh load. The stimulus first shifts two back-to-back words so that the latched output bit and the next bit waiting at the top of the register differ. It then holds load high while it pulses the clock or rewrites the straps. A lost gate or a level-sensitive load then shows up as a changed output bit or a changed channel code.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  localparam int DEF_CODE_W = 8;
  localparam int DEF_CH_W   = 4;
  localparam int DEF_CS_W   = 4;
  localparam int DEF_N_CH   = 8;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacld_shift.sv
module dacld_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               din_s,
  input  logic               load_s,
  output logic [FRAME_W-1:0] frame,
  output logic               so_bit,
  output logic               shift_en,
  output logic               load_rise
);
  logic sclk_d;
  logic load_d;

  // shift clock is gated off for the whole time load is high
  assign shift_en  = sclk_s & ~sclk_d & ~load_s;
  assign load_rise = load_s & ~load_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      load_d <= 1'b0;
      frame  <= '0;
      so_bit <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
      if (shift_en) begin
        frame  <= {frame[FRAME_W-2:0], din_s};
        so_bit <= frame[FRAME_W-1];
      end
    end
  end
endmodule

// File: rtl/dacld_decode.sv
module dacld_decode #(
  parameter int CH_W = 4,
  parameter int CS_W = 4,
  parameter int N_CH = 8
) (
  input  logic [CS_W-1:0] dev_addr,
  input  logic [CS_W-1:0] strap_s,
  input  logic [CH_W-1:0] ch_addr,
  input  logic            load_rise,
  output logic [N_CH-1:0] wr_en
);
  logic dev_hit;

  assign dev_hit = (dev_addr == strap_s);

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_dec
      // addresses at or above N_CH match no slot
      assign wr_en[i] = load_rise & dev_hit & (ch_addr == CH_W'(i));
    end
  endgenerate
endmodule

// File: rtl/dacld_bank.sv
module dacld_bank #(
  parameter int CODE_W = 8,
  parameter int N_CH   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        wr_en,
  input  logic [CODE_W-1:0]      wr_code,
  output logic [N_CH*CODE_W-1:0] codes
);
  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W-1);

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q <= MIDSCALE;
        end else if (wr_en[i]) begin
          code_q <= wr_code;
        end
      end
      assign codes[i*CODE_W +: CODE_W] = code_q;
    end
  endgenerate
endmodule

// File: rtl/dacld_top.sv
module dacld_top
  import dacld_pkg::*;
#(
  parameter int CODE_W = DEF_CODE_W,
  parameter int CH_W   = DEF_CH_W,
  parameter int CS_W   = DEF_CS_W,
  parameter int N_CH   = DEF_N_CH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk,
  input  logic                   ser_din,
  input  logic                   ser_load,
  input  logic [CS_W-1:0]        strap,
  output logic                   ser_dout,
  output logic                   ser_dout_en,
  output logic [N_CH*CODE_W-1:0] codes
);
  localparam int FRAME_W = CS_W + CH_W + CODE_W;
  localparam int SYNC_W  = CS_W + 3;

  logic [SYNC_W-1:0]  raw_in;
  logic [SYNC_W-1:0]  sync_out;
  logic               sclk_s;
  logic               din_s;
  logic               load_s;
  logic [CS_W-1:0]    strap_s;
  logic [FRAME_W-1:0] frame;
  logic               so_bit;
  logic               shift_en;
  logic               load_rise;
  logic [N_CH-1:0]    wr_en;
  logic [CS_W-1:0]    dev_addr;
  logic [CH_W-1:0]    ch_addr;
  logic [CODE_W-1:0]  wr_code;

  assign raw_in = {strap, ser_load, ser_din, ser_clk};

  dacld_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign sclk_s  = sync_out[0];
  assign din_s   = sync_out[1];
  assign load_s  = sync_out[2];
  assign strap_s = sync_out[SYNC_W-1:3];

  dacld_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .din_s     (din_s),
    .load_s    (load_s),
    .frame     (frame),
    .so_bit    (so_bit),
    .shift_en  (shift_en),
    .load_rise (load_rise)
  );

  assign dev_addr = frame[FRAME_W-1 -: CS_W];
  assign ch_addr  = frame[CODE_W +: CH_W];
  assign wr_code  = frame[CODE_W-1:0];

  dacld_decode #(.CH_W(CH_W), .CS_W(CS_W), .N_CH(N_CH)) u_decode (
    .dev_addr  (dev_addr),
    .strap_s   (strap_s),
    .ch_addr   (ch_addr),
    .load_rise (load_rise),
    .wr_en     (wr_en)
  );

  dacld_bank #(.CODE_W(CODE_W), .N_CH(N_CH)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_code (wr_code),
    .codes   (codes)
  );

  assign ser_dout    = so_bit;
  assign ser_dout_en = load_s;
endmodule

// File: rtl/dacld_chk.sv
module dacld_chk #(
  parameter int CODE_W  = 8,
  parameter int CS_W    = 4,
  parameter int N_CH    = 8,
  parameter int FRAME_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load_s,
  input logic                   shift_en,
  input logic                   load_rise,
  input logic [N_CH-1:0]        wr_en,
  input logic [FRAME_W-1:0]     frame,
  input logic [CS_W-1:0]        strap_s,
  input logic                   so_bit,
  input logic [N_CH*CODE_W-1:0] codes
);
  // R5
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  // R6
  gated_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !load_s);

  // R8
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |-> (load_s && !$past(load_s)));

  // R3
  dev_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en != '0) |-> (frame[FRAME_W-1 -: CS_W] == strap_s));

  // R2
  hold_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(codes));

  // R7
  chain_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (so_bit == $past(frame[FRAME_W-1])));
endmodule

bind dacld_top dacld_chk #(
  .CODE_W(CODE_W), .CS_W(CS_W), .N_CH(N_CH), .FRAME_W(FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_s    (load_s),
  .shift_en  (shift_en),
  .load_rise (load_rise),
  .wr_en     (wr_en),
  .frame     (frame),
  .strap_s   (strap_s),
  .so_bit    (so_bit),
  .codes     (codes)
);

// File: tb/dacld_top_bench.sv
module dacld_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_load = 1'b0;
  logic [3:0]  strap = 4'hA;
  logic        ser_dout;
  logic        ser_dout_en;
  logic [63:0] codes;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int done_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] exp_codes;
    logic        exp_dout;
    bit          chk_dout;
    string       req;
  } item_t;

  item_t sb_q[$];
  logic [7:0] model [8];

  always #2.5 clk = ~clk;

  dacld_top u_dacld_top (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .strap(strap), .ser_dout(ser_dout),
    .ser_dout_en(ser_dout_en), .codes(codes)
  );

  function automatic logic [63:0] packed_model();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int b = 15; b >= 0; b--) begin
      @(negedge clk);
      ser_din = w[b];
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_up(input logic exp_dout, input bit chk_dout, input string req);
    item_t it;
    @(negedge clk);
    ser_load = 1'b1;
    it.exp_codes = packed_model();
    it.exp_dout = exp_dout;
    it.chk_dout = chk_dout;
    it.req = req;
    sb_q.push_back(it);
    pushed++;
    wait (done_cnt == pushed);
  endtask

  task automatic load_down();
    repeat (2) @(negedge clk);
    ser_load = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // monitor: pops expected items and compares once the load has taken effect
  initial begin
    item_t it;
    forever begin
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      repeat (6) @(negedge clk);
      check(codes === it.exp_codes, it.req, "channel codes", codes, it.exp_codes);
      check(ser_dout_en === 1'b1, "R7", "dout enable during load",
            64'(ser_dout_en), 64'd1);
      if (it.chk_dout)
        check(ser_dout === it.exp_dout, it.req, "chained bit",
              64'(ser_dout), 64'(it.exp_dout));
      done_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h80;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(codes === 64'h8080808080808080, "R1", "codes in reset", codes, 64'h8080808080808080);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(codes === 64'h8080808080808080, "R1", "codes after reset", codes, 64'h8080808080808080);
    check(ser_dout_en === 1'b0, "R1", "dout enable after reset", 64'(ser_dout_en), 64'd0);

    // R2: basic write to channel 3
    send_word({4'hA, 4'h3, 8'h5C});
    model[3] = 8'h5C;
    load_up(1'b0, 0, "R2"); load_down();
    check(ser_dout_en === 1'b0, "R7", "dout enable after load", 64'(ser_dout_en), 64'd0);

    // R5: edge channels, others untouched
    send_word({4'hA, 4'h0, 8'h01});
    model[0] = 8'h01;
    load_up(1'b0, 0, "R5"); load_down();
    send_word({4'hA, 4'h7, 8'hFE});
    model[7] = 8'hFE;
    load_up(1'b0, 0, "R5"); load_down();

    // R3: device address mismatch
    send_word({4'hB, 4'h1, 8'h33});
    load_up(1'b0, 0, "R3"); load_down();

    // R4: out-of-range channel
    send_word({4'hA, 4'h9, 8'h44});
    load_up(1'b0, 0, "R4"); load_down();

    // R7: chained bit is last bit of the earlier word (code 0x3F, bit0 = 1)
    send_word({4'hA, 4'h1, 8'h3F});
    send_word({4'hA, 4'h2, 8'h81});
    model[2] = 8'h81;
    load_up(1'b1, 1, "R7"); load_down();

    // R6: shift clock pulsed during load must not move the chained bit
    send_word({4'hA, 4'h5, 8'h22});
    send_word({4'hA, 4'h6, 8'h77});
    model[6] = 8'h77;
    load_up(1'b0, 1, "R6");
    ser_din = 1'b1;
    ser_clk = 1'b1;
    repeat (6) @(negedge clk);
    ser_clk = 1'b0;
    repeat (6) @(negedge clk);
    check(ser_dout === 1'b0, "R6", "chained bit after gated pulse", 64'(ser_dout), 64'd0);
    load_down();
    check(ser_dout === 1'b0, "R6", "chained bit after load", 64'(ser_dout), 64'd0);

    // R8: straps change while load is held high: no write
    strap = 4'h5;
    send_word({4'hA, 4'h1, 8'h99});
    load_up(1'b0, 0, "R8");
    strap = 4'hA;
    repeat (10) @(negedge clk);
    check(codes === packed_model(), "R8", "codes with load held", codes, packed_model());
    load_down();
    check(codes === packed_model(), "R8", "codes after load", codes, packed_model());

    // R9: reset after writes
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(codes === 64'h8080808080808080, "R9", "codes after second reset", codes, 64'h8080808080808080);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule